// File: doc/BRIEF.md
# Clock source select register

This block is a byte-wide control register for a microcontroller's clock controller. It holds a two-bit source code, an enable for the main PLL, an enable for the low-speed subclock, and four spare bits. Software reads and writes it over a simple byte bus. The source code picks one of three clocks: the main oscillator halved, the main PLL, or the subclock. The code drives a one-hot selection output and a flag that says whether the chip is in main or subclock mode. Those outputs feed a glitch-free clock multiplexer, which lies outside this block.

A write does not always change the source code. The register checks each requested code against a fixed set of permitted moves. It also checks two run conditions: the PLL must be enabled and locked before the PLL can be chosen, and the subclock must be enabled before the subclock can be chosen. Both conditions use the register contents from before the write. A rejected code leaves the old source in place, while the enable bits and spare bits in the same write still update. A rejection raises an error flag for one cycle. As a result, some moves need an intermediate step. For example, going from reset to the subclock takes a write of 01 and then a write of 11.

The external-pin reset clears the register. The software reset leaves the register contents untouched.

Top module: `clk_src_ctrl`

## Requirements
- R1: The register is decoded at byte address REG_ADDR (default 0x484). Reading it returns {spare[3:0], subclock enable (bit 3), PLL enable (bit 2), source code (bits 1:0)}. Any other address reads 0x00, and a write to any other address changes nothing.
- R2: Bits 7:4 are spare storage. A read returns the value last written to them.
- R3: While pin_rst_n is low, the whole register is cleared. The source code is 00, both enables are 0, and src_err is 0.
- R4: Only these source moves are permitted: 00→01, 00→10, 01→00, 01→11, 10→00 and 11→01. Writing the current code again is always accepted. A write that asks for any other move keeps the old code, but its bits 7:2 still update.
- R5: While source bit 1 is 1, source bit 0 never changes.
- R6: A move to 10 is accepted only if the PLL enable already stored before the write is 1 and pll_lock is 1 in the write cycle.
- R7: A move to 11 is accepted only if the subclock enable already stored before the write is 1.
- R8: src_err is 1 for exactly the cycle after a register write whose source request was rejected. It is 0 after any other cycle.
- R9: In a cycle with sw_rst high, the register keeps its value, a bus write in that cycle is ignored, and src_err is 0 in the next cycle.
- R10: The outputs follow the source code. For codes 00 and 01, src_onehot = 001. For code 10, src_onehot = 010. For code 11, src_onehot = 100. sub_mode is 1 only for code 11.
- R11: Starting from reset, the subclock is reached by setting the subclock enable, then writing code 01, then writing code 11. A direct write of 11 from code 00 is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| pin_rst_n | input | 1 | External-pin reset, asynchronous, active low |
| sw_rst | input | 1 | Software reset; register contents are kept |
| bus_addr | input | ADDR_W | Byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| pll_lock | input | 1 | Main PLL lock indication |
| src_onehot | output | 3 | Selected clock: bit 0 main/2, bit 1 PLL, bit 2 subclock |
| sub_mode | output | 1 | 1 when the chip is in subclock mode |
| pll_en | output | 1 | Main PLL run enable |
| sub_en | output | 1 | Subclock selection enable |
| src_err | output | 1 | One-cycle flag after a rejected source request |

## Verification
The assertions assume three things about the inputs. First, pll_lock and the bus inputs are synchronous to clk. Second, pin_rst_n is held low from time zero for more than one edge. Third, pll_lock is sampled only in the write cycle, so a lock that drops later is not treated as a violation. The stimulus changes inputs only at the falling edge. It releases the pin reset after several cycles and asserts it again once, mid-run, on a falling edge. It toggles pll_lock freely, because the block is required to accept any lock pattern and to gate only the move into the PLL on it.

// File: rtl/clk_src_pkg.sv
package clk_src_pkg;

    typedef enum logic [1:0] {
        SRC_MAIN_A = 2'b00,
        SRC_MAIN_B = 2'b01,
        SRC_PLL    = 2'b10,
        SRC_SUB    = 2'b11
    } src_e;

    localparam int SPARE_W   = 4;
    localparam int NUM_KINDS = 3;

    typedef struct packed {
        logic [SPARE_W-1:0] spare;
        logic               sub_en;
        logic               pll_en;
        src_e               src;
        logic               err;
    } ctrl_state_t;

endpackage

// File: rtl/clk_src_step_filter.sv
module clk_src_step_filter
    import clk_src_pkg::*;
(
    input  src_e cur_src,
    input  src_e req_src,
    input  logic pll_en_now,
    input  logic pll_lock,
    input  logic sub_en_now,
    output logic accept
);
    logic move_ok;
    logic cond_ok;

    always_comb begin
        unique case ({cur_src, req_src})
            {SRC_MAIN_A, SRC_MAIN_B},
            {SRC_MAIN_A, SRC_PLL},
            {SRC_MAIN_B, SRC_MAIN_A},
            {SRC_MAIN_B, SRC_SUB},
            {SRC_PLL,    SRC_MAIN_A},
            {SRC_SUB,    SRC_MAIN_B}: move_ok = 1'b1;
            default:                  move_ok = 1'b0;
        endcase

        cond_ok = 1'b1;
        if (req_src == SRC_PLL && !(pll_en_now && pll_lock)) cond_ok = 1'b0;
        if (req_src == SRC_SUB && !sub_en_now)               cond_ok = 1'b0;

        accept = (req_src == cur_src) || (move_ok && cond_ok);
    end
endmodule

// File: rtl/clk_src_decode.sv
module clk_src_decode
    import clk_src_pkg::*;
#(
    parameter int N_OUT = NUM_KINDS
) (
    input  src_e             src,
    output logic [N_OUT-1:0] onehot,
    output logic             sub_mode
);
    localparam int KIND_W = $clog2(N_OUT);

    logic [KIND_W-1:0] kind;

    always_comb begin
        unique case (src)
            SRC_PLL: kind = KIND_W'(1);
            SRC_SUB: kind = KIND_W'(2);
            default: kind = KIND_W'(0);
        endcase
    end

    for (genvar i = 0; i < N_OUT; i++) begin : g_sel
        assign onehot[i] = (kind == KIND_W'(i));
    end

    assign sub_mode = (src == SRC_SUB);
endmodule

// File: rtl/clk_src_ctrl.sv
module clk_src_ctrl
    import clk_src_pkg::*;
#(
    parameter int              ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] REG_ADDR = 12'h484
) (
    input  logic                 clk,
    input  logic                 pin_rst_n,
    input  logic                 sw_rst,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic [7:0]           bus_wdata,
    output logic [7:0]           bus_rdata,
    input  logic                 pll_lock,
    output logic [NUM_KINDS-1:0] src_onehot,
    output logic                 sub_mode,
    output logic                 pll_en,
    output logic                 sub_en,
    output logic                 src_err
);
    ctrl_state_t state_d, state_q;
    logic        sel_d;
    logic        wr_hit_d;
    logic        accept_d;
    src_e        req_d;
    logic [1:0]  cur_src;

    assign sel_d    = (bus_addr == REG_ADDR);
    assign wr_hit_d = bus_we && sel_d && !sw_rst;
    assign req_d    = src_e'(bus_wdata[1:0]);
    assign cur_src  = state_q.src;

    clk_src_step_filter u_filter (
        .cur_src    (state_q.src),
        .req_src    (req_d),
        .pll_en_now (state_q.pll_en),
        .pll_lock   (pll_lock),
        .sub_en_now (state_q.sub_en),
        .accept     (accept_d)
    );

    always_comb begin
        state_d     = state_q;
        state_d.err = 1'b0;
        if (wr_hit_d) begin
            state_d.spare  = bus_wdata[7:4];
            state_d.sub_en = bus_wdata[3];
            state_d.pll_en = bus_wdata[2];
            if (accept_d) state_d.src = req_d;
            else          state_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge pin_rst_n) begin
        if (!pin_rst_n) state_q <= '0;
        else            state_q <= state_d;
    end

    clk_src_decode #(.N_OUT(NUM_KINDS)) u_decode (
        .src      (state_q.src),
        .onehot   (src_onehot),
        .sub_mode (sub_mode)
    );

    assign bus_rdata = sel_d ? {state_q.spare, state_q.sub_en, state_q.pll_en, state_q.src}
                             : 8'h00;
    assign pll_en  = state_q.pll_en;
    assign sub_en  = state_q.sub_en;
    assign src_err = state_q.err;
endmodule

// File: rtl/clk_src_ctrl_chk.sv
module clk_src_ctrl_chk #(
    parameter int              ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] REG_ADDR = 12'h484
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sw_rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic              pll_lock,
    input logic [1:0]        src,
    input logic [2:0]        src_onehot,
    input logic              sub_mode,
    input logic              pll_en,
    input logic              sub_en,
    input logic              src_err
);
    function automatic logic move_allowed(input logic [1:0] from, input logic [1:0] to);
        logic r;
        r = 1'b0;
        if (from == 2'b00 && (to == 2'b01 || to == 2'b10)) r = 1'b1;
        if (from == 2'b01 && (to == 2'b00 || to == 2'b11)) r = 1'b1;
        if (from == 2'b10 && to == 2'b00) r = 1'b1;
        if (from == 2'b11 && to == 2'b01) r = 1'b1;
        return r;
    endfunction

    p_table_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (src != $past(src)) |-> move_allowed($past(src), src));

    p_low_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(src[1]) && src[1]) |-> (src[0] == $past(src[0])));

    p_pll_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (src == 2'b10 && $past(src) != 2'b10) |-> $past(pll_en && pll_lock));

    p_sub_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (src == 2'b11 && $past(src) != 2'b11) |-> $past(sub_en));

    p_err_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        src_err |-> ($past(bus_we && bus_addr == REG_ADDR && !sw_rst) && src == $past(src)));

    p_swrst_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sw_rst) |-> (src == $past(src) && pll_en == $past(pll_en)
                           && sub_en == $past(sub_en) && !src_err));

    p_decode_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($onehot(src_onehot) && sub_mode == src_onehot[2] && sub_mode == (src == 2'b11)));
endmodule

bind clk_src_ctrl clk_src_ctrl_chk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (
    .clk        (clk),
    .rst_n      (pin_rst_n),
    .sw_rst     (sw_rst),
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .pll_lock   (pll_lock),
    .src        (cur_src),
    .src_onehot (src_onehot),
    .sub_mode   (sub_mode),
    .pll_en     (pll_en),
    .sub_en     (sub_en),
    .src_err    (src_err)
);

// File: tb/clk_src_ctrl_tb.sv
module clk_src_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [11:0] REG = 12'h484;

    logic        clk = 1'b0;
    logic        pin_rst_n = 1'b0;
    logic        sw_rst = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        pll_lock = 1'b0;
    logic [2:0]  src_onehot;
    logic        sub_mode, pll_en, sub_en, src_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // reference model state
    logic [3:0] m_spare = '0;
    logic       m_sub = 1'b0, m_pll = 1'b0, m_err = 1'b0;
    logic [1:0] m_src = 2'b00;
    logic [3:0] allowed_moves[$] = '{4'b0001, 4'b0010, 4'b0100, 4'b0111, 4'b1000, 4'b1101};

    always #(CLK_PERIOD/2) clk = ~clk;

    clk_src_ctrl u_dut (
        .clk(clk), .pin_rst_n(pin_rst_n), .sw_rst(sw_rst), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pll_lock(pll_lock), .src_onehot(src_onehot), .sub_mode(sub_mode),
        .pll_en(pll_en), .sub_en(sub_en), .src_err(src_err)
    );

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    function automatic bit in_table(input logic [1:0] f, input logic [1:0] t);
        foreach (allowed_moves[k]) if (allowed_moves[k] == {f, t}) return 1'b1;
        return 1'b0;
    endfunction

    // one clock: drive at falling edge, check read, advance model, compare at next falling edge
    task automatic step(input logic rst_v, input logic we, input logic [11:0] a,
                        input logic [7:0] d, input logic swr, input logic lk, input string tag);
        logic [7:0] exp_rd;
        logic [2:0] exp_oh;
        bit ok;
        pin_rst_n = rst_v; bus_we = we; bus_addr = a; bus_wdata = d; sw_rst = swr; pll_lock = lk;
        #1;
        if (rst_v) begin
            exp_rd = (a == REG) ? {m_spare, m_sub, m_pll, m_src} : 8'h00;
            chk(bus_rdata === exp_rd, {tag, " R1/R2 read data"}, bus_rdata, exp_rd);
        end
        if (!rst_v) begin
            m_spare = '0; m_sub = 0; m_pll = 0; m_src = 2'b00; m_err = 0;
        end else if (we && a == REG && !swr) begin
            ok = (d[1:0] == m_src) ||
                 (in_table(m_src, d[1:0]) &&
                  (d[1:0] != 2'b10 || (m_pll && lk)) &&
                  (d[1:0] != 2'b11 || m_sub));
            m_spare = d[7:4]; m_sub = d[3]; m_pll = d[2];
            if (ok) m_src = d[1:0];
            m_err = !ok;
        end else begin
            m_err = 1'b0;
        end
        @(posedge clk);
        @(negedge clk);
        exp_oh = (m_src == 2'b10) ? 3'b010 : (m_src == 2'b11) ? 3'b100 : 3'b001;
        chk(src_onehot === exp_oh, {tag, " R10 src_onehot"}, src_onehot, exp_oh);
        chk(sub_mode === (m_src == 2'b11), {tag, " R10 sub_mode"}, sub_mode, m_src == 2'b11);
        chk(pll_en === m_pll, {tag, " R4 pll_en"}, pll_en, m_pll);
        chk(sub_en === m_sub, {tag, " R4 sub_en"}, sub_en, m_sub);
        chk(src_err === m_err, {tag, " R8 src_err"}, src_err, m_err);
    endtask

    task automatic wr(input logic [7:0] d, input logic lk, input string tag);
        step(1'b1, 1'b1, REG, d, 1'b0, lk, tag);
    endtask

    task automatic idle(input string tag);
        step(1'b1, 1'b0, REG, 8'h00, 1'b0, 1'b0, tag);
    endtask

    initial begin
        @(negedge clk);
        step(1'b0, 1'b0, REG, 8'h00, 1'b0, 1'b0, "R3 reset hold");
        step(1'b0, 1'b0, REG, 8'h00, 1'b0, 1'b0, "R3 reset hold");
        idle("R3 after reset");
        // R1 other address
        step(1'b1, 1'b1, 12'h485, 8'hFF, 1'b0, 1'b1, "R1 foreign write");
        step(1'b1, 1'b0, 12'h485, 8'h00, 1'b0, 1'b0, "R1 foreign read");
        // R7 / R11 path to subclock
        wr(8'h03, 1'b0, "R11 direct 00->11");
        wr(8'h01, 1'b0, "R4 00->01");
        wr(8'h03, 1'b0, "R7 11 without sub enable");
        wr(8'h09, 1'b0, "R7 set sub enable");
        wr(8'h0B, 1'b0, "R11 01->11");
        wr(8'h0A, 1'b1, "R5 11->10 forbidden");
        wr(8'h08, 1'b0, "R5 11->00 forbidden");
        wr(8'h0B, 1'b0, "R8 same value");
        wr(8'h09, 1'b0, "R4 11->01");
        wr(8'h0E, 1'b1, "R4 01->10 forbidden");
        wr(8'h08, 1'b0, "R4 01->00");
        wr(8'h0B, 1'b0, "R11 00->11 with enable");
        // R6 PLL gating
        wr(8'h02, 1'b1, "R6 pll not enabled");
        wr(8'h04, 1'b1, "R6 enable pll");
        wr(8'h06, 1'b0, "R6 not locked");
        wr(8'h06, 1'b1, "R6 locked 00->10");
        wr(8'h0F, 1'b1, "R5 10->11 forbidden");
        wr(8'h05, 1'b1, "R5 10->01 forbidden");
        wr(8'h06, 1'b0, "R4 same value lock low");
        wr(8'h04, 1'b0, "R4 10->00");
        // R2 spare bits
        wr(8'hA1, 1'b0, "R2 spare A");
        idle("R2 readback");
        wr(8'h50, 1'b0, "R2 spare 5");
        idle("R2 readback");
        // R9 software reset
        step(1'b1, 1'b1, REG, 8'hFD, 1'b1, 1'b1, "R9 write during sw_rst");
        idle("R9 hold");
        wr(8'h03, 1'b0, "R9 rejected before sw_rst");
        step(1'b1, 1'b0, REG, 8'h00, 1'b1, 1'b0, "R9 sw_rst after reject");
        step(1'b1, 1'b0, REG, 8'h00, 1'b1, 1'b0, "R9 sw_rst hold");
        // R3 mid-run reset
        wr(8'hCD, 1'b0, "R3 load");
        step(1'b0, 1'b0, REG, 8'h00, 1'b0, 1'b0, "R3 pin reset");
        idle("R3 after pin reset");
        // mixed stimulus
        for (int i = 0; i < 400; i++) begin
            logic [11:0] a;
            a = ($urandom % 8 == 0) ? 12'h485 : REG;
            step(1'b1, ($urandom % 4) != 0, a, 8'($urandom), ($urandom % 12) == 0,
                 ($urandom % 3) != 0, "R4 R6 R7 R9 mixed");
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog R1 actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule